// File: doc/BRIEF.md
# Rank Mask-Compare Address Router

This block turns a cell-local line address into a DRAM location for one memory quadrant. It holds one routing register set per rank, eight by default. Each set holds a mask, a compare value and a field layout. A rank is selected when the address bits under its mask equal its compare value. The masked bits are the interleave bits. They are removed from the address, and the surviving bits are packed downward. The bank, row and column fields are then cut from that packed value at positions the selected rank's layout gives. The decode is therefore fully programmable and is not a fixed bit split.

A system normally has four copies, one per quadrant. Each copy is programmed so that consecutive line addresses step first across quadrants, then across the two SDRAM buses, then across the four echelons on a bus, and finally across the banks of a rank. Requests carry a tag, and the result comes back registered one cycle later with the same tag. An address that selects no rank, or more than one rank, gives a decode error and raises no rank strobe. The block has no state machine. Its only sequential state is the configuration registers and one output register stage.

Top module: `rank_route_decoder`

## Requirements
- R1: After reset `rsp_valid` is low. Every rank starts with an all-zero mask and an all-ones compare value, so a request made before programming returns `rsp_err`.
- R2: Each cycle with `req_valid` high produces exactly one cycle with `rsp_valid` high on the next clock. That response carries `req_tag` unchanged. A cycle with no request gives `rsp_valid` low, with `rsp_hit` and `rsp_err` low.
- R3: Rank r matches when `(req_addr & mask_r) == compare_r`. When exactly one rank matches, the response has `rsp_hit` high, `rsp_rank` = r, and `rsp_rank_oh` with only bit r set.
- R4: When no rank matches, or two or more ranks match, the response has `rsp_err` high and `rsp_hit` low. `rsp_rank_oh`, `rsp_rank`, `rsp_bank`, `rsp_row` and `rsp_col` are all zero.
- R5: Address bits where the selected rank's mask is 1 are removed. The remaining bits are packed toward bit 0 in their original order to form the packed address.
- R6: Each of bank, row and column equals packed-address bits [lsb+len-1:lsb], using that field's lsb and len from the selected rank's layout. Bits at positions at or above ADDR_W read as zero.
- R7: A field length above that field's width is treated as the width. The widths are bank 3, row 16 and column 12. A length of 0 gives a zero field.
- R8: Configuration is written while `cfg_we` is high, into the rank named by `cfg_rank`. `cfg_sel` selects the target: 0 = mask, 1 = compare, 2 = layout, 3 = no effect. The layout word is laid out as [5:0] col lsb, [9:6] col len, [15:10] row lsb, [20:16] row len, [26:21] bank lsb and [28:27] bank len. A write applies to requests presented on later cycles. A request in the same cycle as the write is decoded with the old setting.
- R9: With the interleave programming, quadrant q owns a line address A when A[1:0] = q. In that programming, rank r has mask 0x1F and compare = r[2:1]<<3 | r[0]<<2 | q, and its layout is bank lsb 0 len 3, col lsb 3 len 10, row lsb 13 len 16. Under it, the i-th address owned by quadrant q within an aligned 256-line block gives rank = 2*((i/2)%4) + i%2 and bank = (i/8)%8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_rank | input | RIDX_W | Rank whose registers are written |
| cfg_sel | input | 2 | Write target: 0 mask, 1 compare, 2 layout, 3 none |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Cell-local line address |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_hit | output | 1 | Exactly one rank matched |
| rsp_err | output | 1 | Zero or several ranks matched |
| rsp_rank_oh | output | NRANK | One-hot rank strobe |
| rsp_rank | output | RIDX_W | Selected rank index |
| rsp_bank | output | 3 | Bank field |
| rsp_row | output | 16 | Row field |
| rsp_col | output | 12 | Column field |

## Verification
A directed walk over 256 consecutive line addresses under the interleave programming checks the stepping order itself. It shows whether the bus, echelon and bank steps come in the right nesting, and whether addresses owned by other quadrants are refused. Random addresses under the same programming compare every field against a bench model of compaction and extraction. Random masks and layouts, including lengths over the field width and non-contiguous masks, separate errors in bit packing from errors in field cutting and clamping. Directed overlap, empty-match, ignored-write and same-cycle-write cases isolate the error path and the write timing.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 16;
    localparam int COL_W  = 12;

    typedef struct packed {
        logic [1:0] bank_len;
        logic [5:0] bank_lsb;
        logic [4:0] row_len;
        logic [5:0] row_lsb;
        logic [3:0] col_len;
        logic [5:0] col_lsb;
    } layout_t;

    localparam int LAY_W = $bits(layout_t);

    typedef enum logic [1:0] {
        SEL_MASK   = 2'd0,
        SEL_CMP    = 2'd1,
        SEL_LAYOUT = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/rrd_cfg_regs.sv
module rrd_cfg_regs
    import rrd_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int NRANK  = 8,
    localparam int RIDX_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_rank,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] mask_q [NRANK],
    output logic [ADDR_W-1:0] cmp_q  [NRANK],
    output layout_t           lay_q  [NRANK]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NRANK; r++) begin
                mask_q[r] <= '0;
                cmp_q[r]  <= '1;
                lay_q[r]  <= '0;
            end
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_MASK:   mask_q[cfg_rank] <= cfg_wdata;
                SEL_CMP:    cmp_q[cfg_rank]  <= cfg_wdata;
                SEL_LAYOUT: lay_q[cfg_rank]  <= layout_t'(cfg_wdata[LAY_W-1:0]);
                SEL_NONE:   ;
            endcase
        end
    end
endmodule

// File: rtl/rrd_rank_match.sv
module rrd_rank_match #(
    parameter int ADDR_W = 40,
    parameter int NRANK  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mask [NRANK],
    input  logic [ADDR_W-1:0] cmp  [NRANK],
    output logic [NRANK-1:0]  hit
);
    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        assign hit[r] = ((addr & mask[r]) == cmp[r]);
    end
endmodule

// File: rtl/rrd_field_extract.sv
module rrd_field_extract
    import rrd_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mask,
    input  layout_t           lay,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    logic [ADDR_W-1:0] packed_addr;

    // squeeze out the interleave bits, keeping the order of the rest
    always_comb begin
        int j;
        j = 0;
        packed_addr = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (!mask[i]) begin
                packed_addr[j] = addr[i];
                j++;
            end
        end
    end

    always_comb begin
        int idx;
        bank = '0;
        row  = '0;
        col  = '0;
        for (int k = 0; k < BANK_W; k++) begin
            idx = int'(lay.bank_lsb) + k;
            if (k < int'(lay.bank_len) && idx < ADDR_W) bank[k] = packed_addr[idx];
        end
        for (int k = 0; k < ROW_W; k++) begin
            idx = int'(lay.row_lsb) + k;
            if (k < int'(lay.row_len) && idx < ADDR_W) row[k] = packed_addr[idx];
        end
        for (int k = 0; k < COL_W; k++) begin
            idx = int'(lay.col_lsb) + k;
            if (k < int'(lay.col_len) && idx < ADDR_W) col[k] = packed_addr[idx];
        end
    end
endmodule

// File: rtl/rank_route_decoder.sv
module rank_route_decoder
    import rrd_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int NRANK  = 8,
    parameter int TAG_W  = 8,
    localparam int RIDX_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_rank,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [NRANK-1:0]  rsp_rank_oh,
    output logic [RIDX_W-1:0] rsp_rank,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [ROW_W-1:0]  rsp_row,
    output logic [COL_W-1:0]  rsp_col
);
    logic [ADDR_W-1:0] mask_q [NRANK];
    logic [ADDR_W-1:0] cmp_q  [NRANK];
    layout_t           lay_q  [NRANK];
    logic [NRANK-1:0]  hit_vec;
    logic              sel_one;
    logic [RIDX_W-1:0] sel_idx;
    logic [ADDR_W-1:0] sel_mask;
    layout_t           sel_lay;
    logic [BANK_W-1:0] f_bank;
    logic [ROW_W-1:0]  f_row;
    logic [COL_W-1:0]  f_col;

    rrd_cfg_regs #(.ADDR_W(ADDR_W), .NRANK(NRANK)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rank(cfg_rank),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mask_q(mask_q), .cmp_q(cmp_q), .lay_q(lay_q)
    );

    rrd_rank_match #(.ADDR_W(ADDR_W), .NRANK(NRANK)) u_match (
        .addr(req_addr), .mask(mask_q), .cmp(cmp_q), .hit(hit_vec)
    );

    always_comb begin
        sel_one = $onehot(hit_vec);
        sel_idx = '0;
        for (int r = 0; r < NRANK; r++) begin
            if (hit_vec[r]) sel_idx = RIDX_W'(r);
        end
        sel_mask = mask_q[sel_idx];
        sel_lay  = lay_q[sel_idx];
    end

    rrd_field_extract #(.ADDR_W(ADDR_W)) u_ext (
        .addr(req_addr), .mask(sel_mask), .lay(sel_lay),
        .bank(f_bank), .row(f_row), .col(f_col)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_tag     <= '0;
            rsp_hit     <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_rank_oh <= '0;
            rsp_rank    <= '0;
            rsp_bank    <= '0;
            rsp_row     <= '0;
            rsp_col     <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_tag   <= req_valid ? req_tag : '0;
            rsp_hit   <= req_valid && sel_one;
            rsp_err   <= req_valid && !sel_one;
            if (req_valid && sel_one) begin
                rsp_rank_oh <= hit_vec;
                rsp_rank    <= sel_idx;
                rsp_bank    <= f_bank;
                rsp_row     <= f_row;
                rsp_col     <= f_col;
            end else begin
                rsp_rank_oh <= '0;
                rsp_rank    <= '0;
                rsp_bank    <= '0;
                rsp_row     <= '0;
                rsp_col     <= '0;
            end
        end
    end
endmodule

// File: rtl/rrd_checker.sv
module rrd_checker
    import rrd_pkg::*;
#(
    parameter int NRANK  = 8,
    parameter int TAG_W  = 8,
    localparam int RIDX_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [TAG_W-1:0]  req_tag,
    input logic              rsp_valid,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              rsp_hit,
    input logic              rsp_err,
    input logic [NRANK-1:0]  rsp_rank_oh,
    input logic [RIDX_W-1:0] rsp_rank,
    input logic [BANK_W-1:0] rsp_bank,
    input logic [ROW_W-1:0]  rsp_row,
    input logic [COL_W-1:0]  rsp_col
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(req_valid)));                      // R2
    AST_TAG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_valid) |-> (rsp_tag == $past(req_tag)));           // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_err));                            // R2
    AST_HIT_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_err));                               // R3
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($countones(rsp_rank_oh) == 1 && rsp_rank_oh[rsp_rank])); // R3
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rank_oh == '0 && rsp_rank == '0 && rsp_bank == '0
                     && rsp_row == '0 && rsp_col == '0));                  // R4
endmodule

bind rank_route_decoder rrd_checker #(.NRANK(NRANK), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_rank_oh(rsp_rank_oh), .rsp_rank(rsp_rank), .rsp_bank(rsp_bank),
    .rsp_row(rsp_row), .rsp_col(rsp_col)
);

// File: tb/rank_route_decoder_tb_top.sv
module rank_route_decoder_tb_top;
    localparam int ADDR_W = 40;
    localparam int NRANK  = 8;
    localparam int TAG_W  = 8;
    localparam int QUAD   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_rank = '0;
    logic [1:0]        cfg_sel = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              rsp_valid, rsp_hit, rsp_err;
    logic [TAG_W-1:0]  rsp_tag;
    logic [NRANK-1:0]  rsp_rank_oh;
    logic [2:0]        rsp_rank;
    logic [2:0]        rsp_bank;
    logic [15:0]       rsp_row;
    logic [11:0]       rsp_col;

    int n_tests = 0;
    int n_fail  = 0;

    logic [ADDR_W-1:0] m_mask [NRANK];
    logic [ADDR_W-1:0] m_cmp  [NRANK];
    logic [28:0]       m_lay  [NRANK];

    always #5 clk = ~clk;

    rank_route_decoder #(.ADDR_W(ADDR_W), .NRANK(NRANK), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rank(cfg_rank),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_rank_oh(rsp_rank_oh), .rsp_rank(rsp_rank), .rsp_bank(rsp_bank),
        .rsp_row(rsp_row), .rsp_col(rsp_col)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [28:0] mk_lay(int blsb, int blen, int rlsb, int rlen, int clsb, int clen);
        return {blen[1:0], blsb[5:0], rlen[4:0], rlsb[5:0], clen[3:0], clsb[5:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] m_pack(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] m);
        logic [ADDR_W-1:0] r = '0;
        int j = 0;
        for (int i = 0; i < ADDR_W; i++) if (!m[i]) begin r[j] = a[i]; j++; end
        return r;
    endfunction

    function automatic logic [15:0] m_field(logic [ADDR_W-1:0] p, int lsb, int len, int maxw);
        logic [15:0] r = '0;
        int l = (len > maxw) ? maxw : len;
        for (int k = 0; k < l; k++) if (lsb + k < ADDR_W) r[k] = p[lsb+k];
        return r;
    endfunction

    task automatic cfg_write(input int rank, input int sel, input logic [ADDR_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rank = rank[2:0]; cfg_sel = sel[1:0]; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) m_mask[rank] = data;
        if (sel == 1) m_cmp[rank] = data;
        if (sel == 2) m_lay[rank] = data[28:0];
    endtask

    // send one request and compare the registered response with the model
    task automatic send_check(input logic [ADDR_W-1:0] a, input string tagname);
        logic [NRANK-1:0] hv;
        int nhit, r;
        logic [ADDR_W-1:0] p;
        logic [28:0] ly;
        logic [2:0] eb; logic [15:0] er; logic [11:0] ec;
        logic [TAG_W-1:0] t;
        t = TAG_W'($urandom);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_tag = t;
        hv = '0; nhit = 0; r = 0;
        for (int k = 0; k < NRANK; k++)
            if ((a & m_mask[k]) == m_cmp[k]) begin hv[k] = 1'b1; nhit++; r = k; end
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_tag == t, {tagname, " R2 valid/tag"}, {rsp_valid, rsp_tag}, {1'b1, t});
        if (nhit == 1) begin
            p = m_pack(a, m_mask[r]);
            ly = m_lay[r];
            eb = 3'(m_field(p, ly[26:21], ly[28:27], 3));
            er = m_field(p, ly[15:10], ly[20:16], 16);
            ec = 12'(m_field(p, ly[5:0], ly[9:6], 12));
            check(rsp_hit && !rsp_err && rsp_rank == r[2:0] && rsp_rank_oh == hv,
                  {tagname, " R3 rank"}, {rsp_hit, rsp_rank_oh, rsp_rank}, {1'b1, hv, r[2:0]});
            check(rsp_bank == eb && rsp_row == er && rsp_col == ec,
                  {tagname, " R5 R6 fields"}, {rsp_bank, rsp_row, rsp_col}, {eb, er, ec});
        end else begin
            check(rsp_err && !rsp_hit && rsp_rank_oh == 0 && rsp_rank == 0 &&
                  rsp_bank == 0 && rsp_row == 0 && rsp_col == 0,
                  {tagname, " R4 error"}, {rsp_err, rsp_hit, rsp_rank_oh, rsp_bank, rsp_row, rsp_col}, 64'h1 << 45);
        end
    endtask

    task automatic program_interleave();
        for (int r = 0; r < NRANK; r++) begin
            cfg_write(r, 0, 40'h1F);
            cfg_write(r, 1, ADDR_W'(((r >> 1) << 3) | ((r & 1) << 2) | QUAD));
            cfg_write(r, 2, ADDR_W'(mk_lay(0, 3, 13, 16, 3, 10)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < NRANK; r++) begin
            m_mask[r] = '0; m_cmp[r] = '1; m_lay[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !rsp_hit && !rsp_err, "R1 reset outputs", {rsp_valid, rsp_hit, rsp_err}, 0);
        send_check(40'h12345, "R1 unprogrammed");
        check(rsp_err, "R1 unprogrammed err", rsp_err, 1);
        @(negedge clk);
        check(!rsp_valid, "R2 idle cycle", rsp_valid, 0);

        program_interleave();

        // R9: walk 256 consecutive lines of an aligned block
        begin
            int i = 0;
            for (int k = 0; k < 256; k++) begin
                logic [ADDR_W-1:0] a;
                a = ADDR_W'(40'h7_3000 + k);
                send_check(a, "R9 walk");
                if ((k & 3) == QUAD) begin
                    int er, eb;
                    er = 2 * ((i / 2) % 4) + (i % 2);
                    eb = (i / 8) % 8;
                    check(rsp_hit && rsp_rank == er[2:0] && rsp_bank == eb[2:0],
                          "R9 skip order", {rsp_rank, rsp_bank}, {er[2:0], eb[2:0]});
                    i++;
                end else begin
                    check(rsp_err, "R9 foreign quadrant", rsp_err, 1);
                end
            end
        end

        for (int n = 0; n < 300; n++) send_check(ADDR_W'({$urandom, $urandom}), "R3 random");

        // R8: select code 3 leaves rank 0 untouched
        cfg_write(0, 3, '0);
        send_check(ADDR_W'(40'h0_0400 | QUAD), "R8 ignored sel");
        check(rsp_hit && rsp_rank == 0, "R8 ignored sel rank", rsp_rank, 0);

        // R8: a write in the same cycle as a request uses the old setting
        @(negedge clk);
        cfg_we = 1'b1; cfg_rank = 3'd0; cfg_sel = 2'd1; cfg_wdata = '1;
        req_valid = 1'b1; req_addr = ADDR_W'(QUAD); req_tag = 8'h5A;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_cmp[0] = '1;
        check(rsp_hit && rsp_rank == 0 && rsp_tag == 8'h5A, "R8 same-cycle old config", {rsp_hit, rsp_rank}, {1'b1, 3'd0});
        send_check(ADDR_W'(QUAD), "R8 new config");
        check(rsp_err, "R8 write took effect", rsp_err, 1);

        // R4: two ranks with identical selectors
        cfg_write(0, 1, ADDR_W'(QUAD));
        cfg_write(7, 0, 40'h1F);
        cfg_write(7, 1, ADDR_W'(((6 >> 1) << 3) | QUAD));
        send_check(ADDR_W'(((6 >> 1) << 3) | QUAD), "R4 overlap");
        check(rsp_err && rsp_rank_oh == 0, "R4 overlap strobe", rsp_rank_oh, 0);

        // R7: over-long lengths clamp, zero length empties the field
        cfg_write(1, 2, ADDR_W'(mk_lay(30, 3, 2, 31, 0, 15)));
        send_check(40'hFF_FFFF_FFE4 | ADDR_W'(QUAD), "R7 clamp");
        check(rsp_row == 16'hFFFF && rsp_col == 12'hFFF, "R7 clamp max", {rsp_row, rsp_col}, {16'hFFFF, 12'hFFF});
        cfg_write(1, 2, ADDR_W'(mk_lay(0, 0, 0, 0, 0, 0)));
        send_check(40'hFF_FFFF_FFE4 | ADDR_W'(QUAD), "R7 zero len");
        check(rsp_bank == 0 && rsp_row == 0 && rsp_col == 0, "R7 zero length", {rsp_bank, rsp_row, rsp_col}, 0);

        // R5 R6: random non-contiguous masks and layouts on rank 2
        for (int n = 0; n < 60; n++) begin
            logic [ADDR_W-1:0] mk;
            mk = ADDR_W'({$urandom, $urandom}) & 40'hFF_0F0F_F0F0;
            cfg_write(2, 0, mk);
            cfg_write(2, 1, '0);
            cfg_write(2, 2, ADDR_W'(mk_lay($urandom % 40, $urandom % 4, $urandom % 40,
                                           $urandom % 32, $urandom % 40, $urandom % 16)));
            for (int q = 0; q < 4; q++)
                send_check(ADDR_W'({$urandom, $urandom}) & ~mk, "R5 R6 packing");
            cfg_write(2, 1, '1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule